// File: doc/BRIEF.md
# Flash Rewrite Controller with Suspend

This block sequences word programming and block erasure on a small on-chip flash array, modelled as a register file, for a CPU that rewrites its own code storage. Software writes a control register (global rewrite enable, two block locks, rewrite mode, suspend enable, two suspend requests) and issues commands on a single-cycle command port. Operation time comes from internal cycle counters: `PROG_CYC` cycles for a program and `ERASE_CYC` active cycles for a block erase.

A shared read port returns either array data or a status byte. An erase can be paused partway through and then resumed with its remaining time kept. A program always runs to completion first, and the controller suspends afterwards if a request is still active. In mode 0, software requests a suspend through control bits and the read port lands on status after an operation. In mode 1, an interrupt request triggers the suspend, the read port lands on array data, and the read-status command is refused.

Top module: `flash_rewrite_ctrl`

## Requirements
- R1: After reset: `ready_o`=1, `suspended_o`=0, both error flags 0, read port in array mode, every array word all ones. Control reset value: locks set, everything else 0. Control bits: [0] rewrite enable, [1] lock block 0, [2] lock block 1, [3] mode 1, [4] suspend enable, [5] erase-suspend request, [6] program-suspend request.
- R2: Command code 4 (program) replaces the target word with old AND data. The write lands `PROG_CYC` cycles after the command is accepted, and `ready_o` is 0 for that time.
- R3: Command code 5 (erase) sets every word of the addressed block (`BLK_WORDS` words, block = high address bits) to all ones after `ERASE_CYC` non-suspended cycles.
- R4: A program or erase is refused when rewrite enable is 0, or when it targets block 0 with lock 0 set, or block 1 with lock 1 set. A refusal sets the matching error flag and leaves the array unchanged.
- R5: A program or erase issued while an operation is running or suspended is ignored and sets the matching error flag.
- R6: In mode 0, after completion the read port shows status: bit 7 ready, bit 5 erase error, bit 4 program error, other bits 0. Command 1 (read array) returns the port to array data. Command 2 (read status) selects status.
- R7: In mode 1, after completion the read port shows array data, and command 2 is ignored.
- R8: In mode 0, with suspend enable and erase-suspend request both 1, a running erase pauses: `suspended_o`=1, `ready_o`=1, and array data is readable. Clearing the request resumes the erase with its remaining cycle count preserved.
- R9: A program-suspend condition during a program does not abort it. The suspend is entered only after the word is written, and it is left when the condition drops.
- R10: In mode 1, the suspend condition is suspend enable AND `irq_i`. Without suspend enable, `irq_i` has no effect.
- R11: Command 3 (clear status) clears both error flags.
- R12: While busy (`ready_o`=0), the read port shows the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 7 | Control register write value |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 3 | Command code |
| cmd_addr_i | input | ADDR_W | Target word address |
| cmd_data_i | input | DATA_W | Program data |
| irq_i | input | 1 | Maskable interrupt request |
| rd_addr_i | input | ADDR_W | Read port address |
| rd_data_o | output | DATA_W | Array word or status byte |
| ready_o | output | 1 | No program or erase running |
| suspended_o | output | 1 | Operation suspended |
| prog_err_o | output | 1 | Program error flag |
| erase_err_o | output | 1 | Erase error flag |

## Verification
Every cycle, the assertions check the following:
- a program never leaves its running state before its last cycle;
- the erase counter holds while suspended;
- a written word equals the old word ANDed with the data;
- an erased block reads all ones;
- refusals raise their error flag;
- clear-status clears both flags;
- mode 1 refuses read-status;
- mode 0 lands on status.

Only the bench's scenarios show end-to-end behaviour: the exact resume timing after a long pause, the data visible through the read port during each suspend type, the interplay of mode, lock bits and interrupt over a sequence of operations, and the status byte contents at each step.

// File: rtl/flash_rw_pkg.sv
`timescale 1ns/1ps
package flash_rw_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_RD_ARRAY = 3'd1,
    OP_RD_STAT  = 3'd2,
    OP_CLR_STAT = 3'd3,
    OP_PROG     = 3'd4,
    OP_ERASE    = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_ERASE, ST_ERASE_SUSP, ST_PROG_SUSP
  } seq_e;

  // packed MSB first: bit 0 is rew_en
  typedef struct packed {
    logic prog_susp_req;
    logic erase_susp_req;
    logic susp_en;
    logic mode1;
    logic lock1;
    logic lock0;
    logic rew_en;
  } ctl_t;

  localparam ctl_t CTL_RST = '{prog_susp_req: 1'b0, erase_susp_req: 1'b0,
                               susp_en: 1'b0, mode1: 1'b0, lock1: 1'b1,
                               lock0: 1'b1, rew_en: 1'b0};
endpackage

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard import flash_rw_pkg::*; #(
  parameter int BLK_W = 2
) (
  input  ctl_t             ctl_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             idle_i,
  output logic             start_prog_o,
  output logic             start_erase_o,
  output logic             rej_prog_o,
  output logic             rej_erase_o
);
  logic writable, ok, is_prog, is_erase;

  always_comb begin
    writable = ctl_i.rew_en;
    if (blk_i == BLK_W'(0) && ctl_i.lock0) writable = 1'b0;
    if (blk_i == BLK_W'(1) && ctl_i.lock1) writable = 1'b0;
  end

  assign ok            = writable && idle_i;
  assign is_prog       = cmd_valid_i && (cmd_e'(cmd_i) == OP_PROG);
  assign is_erase      = cmd_valid_i && (cmd_e'(cmd_i) == OP_ERASE);
  assign start_prog_o  = is_prog && ok;
  assign start_erase_o = is_erase && ok;
  assign rej_prog_o    = is_prog && !ok;
  assign rej_erase_o   = is_erase && !ok;
endmodule

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
module flash_seq import flash_rw_pkg::*; #(
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_prog_i,
  input  logic start_erase_i,
  input  logic susp_e_i,
  input  logic susp_p_i,
  output seq_e state_o,
  output logic prog_fire_o,
  output logic erase_fire_o
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last         = (cnt_q == CNT_W'(1));
  assign prog_fire_o  = (state_q == ST_PROG) && last;
  assign erase_fire_o = (state_q == ST_ERASE) && !susp_e_i && last;
  assign state_o      = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE:
          if (start_prog_i) begin
            state_q <= ST_PROG;
            cnt_q   <= CNT_W'(PROG_CYC);
          end else if (start_erase_i) begin
            state_q <= ST_ERASE;
            cnt_q   <= CNT_W'(ERASE_CYC);
          end
        ST_PROG:
          if (last) state_q <= susp_p_i ? ST_PROG_SUSP : ST_IDLE;
          else      cnt_q   <= cnt_q - CNT_W'(1);
        ST_ERASE:
          if (susp_e_i)  state_q <= ST_ERASE_SUSP;  // count held
          else if (last) state_q <= ST_IDLE;
          else           cnt_q   <= cnt_q - CNT_W'(1);
        ST_ERASE_SUSP:
          if (!susp_e_i) state_q <= ST_ERASE;
        ST_PROG_SUSP:
          if (!susp_p_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_prog_not_aborted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && !last) |=> (state_q == ST_PROG));
  assert_susp_keeps_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASE_SUSP) |=> $stable(cnt_q));
  assert_erase_resumes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASE_SUSP && !susp_e_i) |=> (state_q == ST_ERASE));
endmodule

// File: rtl/flash_array.sv
`timescale 1ns/1ps
module flash_array #(
  parameter int DATA_W    = 8,
  parameter int WORDS     = 16,
  parameter int BLK_WORDS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       prog_i,
  input  logic                       erase_i,
  input  logic [$clog2(WORDS)-1:0]   op_addr_i,
  input  logic [DATA_W-1:0]          op_data_i,
  input  logic [$clog2(WORDS)-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o
);
  localparam int ADDR_W = $clog2(WORDS);
  localparam int OFF_W  = $clog2(BLK_WORDS);

  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q <= '1;
      else if (erase_i && WA[ADDR_W-1:OFF_W] == op_addr_i[ADDR_W-1:OFF_W])
        word_q <= '1;
      else if (prog_i && op_addr_i == WA)
        word_q <= word_q & op_data_i;  // bits only fall 1 -> 0
    end
    assign words[w] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];

  assert_prog_and_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> words[$past(op_addr_i)] == ($past(words[op_addr_i]) & $past(op_data_i)));
  assert_erase_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> words[{$past(op_addr_i[ADDR_W-1:OFF_W]), OFF_W'(0)}] == '1);
endmodule

// File: rtl/flash_rewrite_ctrl.sv
`timescale 1ns/1ps
module flash_rewrite_ctrl import flash_rw_pkg::*; #(
  parameter int DATA_W    = 8,
  parameter int WORDS     = 16,
  parameter int BLK_WORDS = 4,
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 8,
  localparam int ADDR_W   = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [6:0]        ctl_wdata_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              irq_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ready_o,
  output logic              suspended_o,
  output logic              prog_err_o,
  output logic              erase_err_o
);
  localparam int OFF_W = $clog2(BLK_WORDS);
  localparam int BLK_W = ADDR_W - OFF_W;

  ctl_t              ctl_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;
  logic              perr_q, eerr_q, stat_q;
  logic              start_prog, start_erase, rej_prog, rej_erase;
  logic              prog_fire, erase_fire, susp_e, susp_p;
  logic              busy, susp, idle;
  seq_e              state;
  logic [DATA_W-1:0] arr_rd, stat_word;
  cmd_e              cmd;

  assign cmd  = cmd_e'(cmd_i);
  assign busy = (state == ST_PROG) || (state == ST_ERASE);
  assign susp = (state == ST_ERASE_SUSP) || (state == ST_PROG_SUSP);
  assign idle = (state == ST_IDLE);

  // mode 1: interrupt triggers; mode 0: software request bit
  assign susp_e = ctl_q.susp_en && (ctl_q.mode1 ? irq_i : ctl_q.erase_susp_req);
  assign susp_p = ctl_q.susp_en && (ctl_q.mode1 ? irq_i : ctl_q.prog_susp_req);

  flash_guard #(.BLK_W(BLK_W)) i_guard (
    .ctl_i(ctl_q), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .blk_i(cmd_addr_i[ADDR_W-1:OFF_W]), .idle_i(idle),
    .start_prog_o(start_prog), .start_erase_o(start_erase),
    .rej_prog_o(rej_prog), .rej_erase_o(rej_erase)
  );

  flash_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_prog_i(start_prog), .start_erase_i(start_erase),
    .susp_e_i(susp_e), .susp_p_i(susp_p),
    .state_o(state), .prog_fire_o(prog_fire), .erase_fire_o(erase_fire)
  );

  flash_array #(.DATA_W(DATA_W), .WORDS(WORDS), .BLK_WORDS(BLK_WORDS)) i_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_i(prog_fire), .erase_i(erase_fire),
    .op_addr_i(op_addr_q), .op_data_i(op_data_q),
    .rd_addr_i(rd_addr_i), .rd_data_o(arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= CTL_RST;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else begin
      if (ctl_we_i) ctl_q <= ctl_t'(ctl_wdata_i);
      if (start_prog || start_erase) begin
        op_addr_q <= cmd_addr_i;
        op_data_q <= cmd_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (cmd_valid_i && cmd == OP_CLR_STAT) begin
        perr_q <= 1'b0;
        eerr_q <= 1'b0;
      end
      if (rej_prog)  perr_q <= 1'b1;
      if (rej_erase) eerr_q <= 1'b1;
      if (cmd_valid_i && cmd == OP_RD_ARRAY) stat_q <= 1'b0;
      else if (cmd_valid_i && cmd == OP_RD_STAT && !ctl_q.mode1) stat_q <= 1'b1;
      if (prog_fire || erase_fire) stat_q <= !ctl_q.mode1;  // completion wins
    end
  end

  always_comb begin
    stat_word    = '0;
    stat_word[7] = !busy;
    stat_word[5] = eerr_q;
    stat_word[4] = perr_q;
  end

  assign rd_data_o   = (busy || (stat_q && !susp)) ? stat_word : arr_rd;
  assign ready_o     = !busy;
  assign suspended_o = susp;
  assign prog_err_o  = perr_q;
  assign erase_err_o = eerr_q;

  assert_busy_reject_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd == OP_PROG && !idle) |=> prog_err_o);
  assert_disabled_reject_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd == OP_ERASE && !ctl_q.rew_en) |=> erase_err_o);
  assert_clear_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd == OP_CLR_STAT) |=> (!prog_err_o && !erase_err_o));
  assert_mode1_no_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.mode1 && cmd_valid_i && cmd == OP_RD_STAT && !stat_q && !prog_fire && !erase_fire)
      |=> !stat_q);
  assert_mode0_lands_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((prog_fire || erase_fire) && !ctl_q.mode1) |=> stat_q);
endmodule

// File: tb/test_flash_rewrite_ctrl.sv
`timescale 1ns/1ps
module test_flash_rewrite_ctrl;
  localparam int PROG_CYC  = 3;
  localparam int ERASE_CYC = 8;
  localparam logic [6:0] EN = 7'h01, L0 = 7'h02, M1 = 7'h08, SE = 7'h10,
                         ESR = 7'h20, PSR = 7'h40;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ctl_we = 1'b0, cmd_valid = 1'b0, irq = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic [2:0] cmd = '0;
  logic [3:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0, rd_data;
  logic       ready, suspended, perr, eerr;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  flash_rewrite_ctrl i_flash_rewrite_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .irq_i(irq), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ready_o(ready),
    .suspended_o(suspended), .prog_err_o(perr), .erase_err_o(eerr)
  );

  // reference model: 0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program-suspended
  int         m_state, m_left, m_addr, st;
  logic [7:0] m_data;
  logic [7:0] m_mem [16];
  logic [6:0] m_ctl;
  bit         m_perr, m_eerr, m_stat, se, sp, done;

  function automatic bit wr_ok(int a, logic [6:0] c);
    int b = a / 4;
    return c[0] && !(b == 0 && c[1]) && !(b == 1 && c[2]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_left = 0; m_perr = 0; m_eerr = 0; m_stat = 0;
      m_ctl = 7'b0000110; m_addr = 0; m_data = '0;
      for (int i = 0; i < 16; i++) m_mem[i] = 8'hFF;
    end else begin
      st = m_state; done = 0;
      se = m_ctl[4] && (m_ctl[3] ? irq : m_ctl[5]);
      sp = m_ctl[4] && (m_ctl[3] ? irq : m_ctl[6]);
      case (st)
        1: if (m_left == 1) begin
             m_mem[m_addr] = m_mem[m_addr] & m_data; done = 1; m_state = sp ? 4 : 0;
           end else m_left--;
        2: if (se) m_state = 3;
           else if (m_left == 1) begin
             for (int i = 0; i < 16; i++) if (i / 4 == m_addr / 4) m_mem[i] = 8'hFF;
             done = 1; m_state = 0;
           end else m_left--;
        3: if (!se) m_state = 2;
        4: if (!sp) m_state = 0;
        default: ;
      endcase
      if (cmd_valid) begin
        case (cmd)
          3'd1: m_stat = 0;
          3'd2: if (!m_ctl[3]) m_stat = 1;
          3'd3: begin m_perr = 0; m_eerr = 0; end
          3'd4: if (st == 0 && wr_ok(int'(cmd_addr), m_ctl)) begin
                  m_state = 1; m_left = PROG_CYC; m_addr = int'(cmd_addr); m_data = cmd_data;
                end else m_perr = 1;
          3'd5: if (st == 0 && wr_ok(int'(cmd_addr), m_ctl)) begin
                  m_state = 2; m_left = ERASE_CYC; m_addr = int'(cmd_addr);
                end else m_eerr = 1;
          default: ;
        endcase
      end
      if (done) m_stat = !m_ctl[3];
      if (ctl_we) m_ctl = ctl_wdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit b, s;
      logic [7:0] e_rd;
      b = (m_state == 1 || m_state == 2);
      s = (m_state >= 3);
      e_rd = (b || (m_stat && !s)) ? {!b, 1'b0, m_eerr, m_perr, 4'b0} : m_mem[rd_addr];
      chk(cur_req, int'({ready, suspended, perr, eerr, rd_data}),
                   int'({!b, s, m_perr, m_eerr, e_rd}));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic set_ctl(logic [6:0] v);
    ctl_we = 1; ctl_wdata = v; step(1); ctl_we = 0;
  endtask
  task automatic issue(logic [2:0] c, logic [3:0] a, logic [7:0] d);
    cmd_valid = 1; cmd = c; cmd_addr = a; cmd_data = d; step(1); cmd_valid = 0;
  endtask
  task automatic peek(logic [3:0] a);
    rd_addr = a; #1;
  endtask

  initial begin
    #1000;
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(2); rst_n = 1; step(1);
    cur_req = "R1";
    peek(4'd0);
    chk("R1", int'({ready, suspended, perr, eerr}), 4'b1000);
    chk("R1", rd_data, 8'hFF);

    cur_req = "R4";
    issue(3'd4, 4'd9, 8'hA5);
    chk("R4", perr, 1);
    peek(4'd9); chk("R4", rd_data, 8'hFF);
    cur_req = "R11";
    issue(3'd3, 0, 0);
    chk("R11", perr, 0);

    cur_req = "R5";
    set_ctl(EN);
    issue(3'd4, 4'd9, 8'hA5);
    chk("R12", rd_data, 8'h00);
    issue(3'd5, 4'd0, 0);
    chk("R5", eerr, 1);
    step(3);
    cur_req = "R6";
    chk("R6", rd_data, 8'hA0);
    issue(3'd1, 0, 0);
    chk("R2", rd_data, 8'hA5);
    issue(3'd3, 0, 0);
    cur_req = "R2";
    issue(3'd4, 4'd9, 8'h0F);
    step(PROG_CYC + 1);
    issue(3'd1, 0, 0);
    chk("R2", rd_data, 8'h05);
    issue(3'd2, 0, 0);
    chk("R6", rd_data, 8'h80);
    issue(3'd1, 0, 0);

    cur_req = "R4";
    set_ctl(EN | L0);
    issue(3'd4, 4'd1, 8'h00);
    chk("R4", perr, 1);
    peek(4'd1); chk("R4", rd_data, 8'hFF);
    issue(3'd3, 0, 0);

    cur_req = "R8";
    set_ctl(EN | SE);
    issue(3'd5, 4'd8, 0);
    step(3);
    set_ctl(EN | SE | ESR);
    step(4);
    peek(4'd9);
    chk("R8", int'({ready, suspended}), 2'b11);
    issue(3'd1, 0, 0);
    chk("R8", rd_data, 8'h05);
    set_ctl(EN | SE);
    step(2);
    chk("R8", suspended, 0);
    step(ERASE_CYC + 2);
    cur_req = "R3";
    chk("R3", ready, 1);
    issue(3'd1, 0, 0);
    chk("R3", rd_data, 8'hFF);
    peek(4'd11); chk("R3", rd_data, 8'hFF);

    cur_req = "R9";
    set_ctl(EN | SE | PSR);
    issue(3'd4, 4'd10, 8'h3C);
    chk("R9", int'({ready, suspended}), 2'b00);
    step(PROG_CYC + 1);
    peek(4'd10);
    chk("R9", int'({ready, suspended}), 2'b11);
    chk("R9", rd_data, 8'h3C);
    set_ctl(EN | SE);
    step(1);
    chk("R9", suspended, 0);

    cur_req = "R7";
    set_ctl(EN | M1);
    issue(3'd4, 4'd11, 8'h77);
    step(PROG_CYC + 1);
    peek(4'd11);
    chk("R7", rd_data, 8'h77);
    issue(3'd2, 0, 0);
    chk("R7", rd_data, 8'h77);

    cur_req = "R10";
    issue(3'd5, 4'd12, 0);
    irq = 1;
    step(3);
    chk("R10", suspended, 0);
    irq = 0;
    step(ERASE_CYC + 2);
    set_ctl(EN | M1 | SE);
    issue(3'd4, 4'd13, 8'h00);
    step(PROG_CYC + 1);
    issue(3'd5, 4'd12, 0);
    step(2);
    irq = 1;
    step(3);
    chk("R10", int'({ready, suspended}), 2'b11);
    peek(4'd13); chk("R10", rd_data, 8'h00);
    irq = 0;
    step(ERASE_CYC + 2);
    chk("R10", ready, 1);
    chk("R3", rd_data, 8'hFF);

    step(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule